// File: doc/BRIEF.md
# Unsigned Subtractor with Sign-and-Magnitude Result

This block takes two unsigned operands of equal width, a minuend and a subtrahend, and returns their difference as a magnitude plus a sign flag. It never returns a wrapped two's-complement value. The difference is formed by adding the minuend to the inverted subtrahend with a carry-in of one. This gives minuend minus subtrahend plus 2^W, and the carry out of the top bit reports which operand was larger.

When that end carry is set, the raw sum is already the magnitude. When it is clear, the raw sum is complemented a second time, by an inverter and an incrementer. A multiplexer steered by the inverted end carry chooses between the two. The raw end carry is brought out as a debug signal.

A parameter selects whether the outputs pass straight through or go through one register stage. The register stage carries a valid bit and loads only while the input is marked valid.

Top module: `usub_signmag`

## Requirements
- R1: `end_carry` is 1 exactly when `op_m` >= `op_n`, because it is the carry out of bit W-1 of `op_m` + ~`op_n` + 1.
- R2: When `op_m` > `op_n`, `mag` equals `op_m` - `op_n` and `neg` is 0 (for example 0x54 - 0x43 at W=8 gives 0x11).
- R3: When `op_m` < `op_n`, `mag` equals `op_n` - `op_m` and `neg` is 1 (for example 0x43 - 0x54 at W=8 gives 0x11 negative, and 4 - 7 at W=4 gives 3 negative).
- R4: When `op_m` equals `op_n`, `mag` is 0 and `neg` is 0. A negative zero is never produced.
- R5: `neg` is always the inverse of `end_carry` for the same result.
- R6: With OUT_REG=1, `mag`, `neg`, `end_carry` and `out_valid` appear one rising clock edge after the inputs are sampled, and `out_valid` is `in_valid` delayed by one edge. With OUT_REG=0, the outputs follow the inputs combinationally and `out_valid` equals `in_valid`.
- R7: With OUT_REG=1, a cycle with `in_valid` low leaves `mag`, `neg` and `end_carry` unchanged, whatever the operands are.
- R8: With OUT_REG=1, while `rst_n` is low and for the two edges after it rises, `out_valid`, `mag`, `neg` and `end_carry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| in_valid | input | 1 | Operands are valid this cycle |
| op_m | input | W | Unsigned minuend |
| op_n | input | W | Unsigned subtrahend |
| out_valid | output | 1 | Result is valid |
| mag | output | W | Magnitude of op_m - op_n |
| neg | output | 1 | 1 when the difference is negative |
| end_carry | output | 1 | Raw carry out of the complement adder (debug) |

## Verification
With the register stage, every result is due one rising edge after the operands are sampled. The bench drives inputs on a falling edge and checks on the next falling edge. Just after driving, it also checks that the registered `out_valid` has not yet risen. The 16-bit instance is built without the register stage, so its outputs are due in the same cycle; they are checked at the same falling edge, by which time they have long settled. Expected magnitude and sign come from integer subtraction in the bench.

// File: rtl/usm_pkg.sv
package usm_pkg;
  typedef enum logic {
    SGN_POS = 1'b0,
    SGN_NEG = 1'b1
  } sign_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/usm_rst_sync.sv
module usm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/usm_cpl_adder.sv
module usm_cpl_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] raw,
  output logic         carry
);
  logic [W:0]   c;
  logic [W-1:0] b_inv;

  assign c[0]  = 1'b1;
  assign b_inv = ~b;

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic p, g;
    assign p        = a[i] ^ b_inv[i];
    assign g        = a[i] & b_inv[i];
    assign raw[i]   = p ^ c[i];
    assign c[i+1]   = g | (p & c[i]);
  end

  assign carry = c[W];

  always_comb begin
    if (!$isunknown({a, b})) begin
      a_r1_carry_ge: assert (carry == (a >= b))
        else $error("carry disagrees with operand order");
    end
  end
endmodule

// File: rtl/usm_magfix.sv
module usm_magfix #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] raw,
  input  logic         carry,
  output logic [W-1:0] mag
);
  logic [W-1:0] inv;
  logic [W-1:0] inc;
  logic [W:0]   k;

  assign inv  = ~raw;
  assign k[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_inc
    assign inc[i]   = inv[i] ^ k[i];
    assign k[i+1]   = inv[i] & k[i];
  end

  assign mag = carry ? raw : inc;

  always_comb begin
    if (!$isunknown({raw, carry})) begin
      a_r3_recomplement: assert (carry || (W'(mag + raw) == '0))
        else $error("second complement wrong");
      a_r2_passthru: assert (!carry || (mag == raw))
        else $error("raw sum not passed through");
    end
  end
endmodule

// File: rtl/usub_signmag.sv
module usub_signmag #(
  parameter int unsigned W       = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_m,
  input  logic [W-1:0] op_n,
  output logic         out_valid,
  output logic [W-1:0] mag,
  output logic         neg,
  output logic         end_carry
);
  import usm_pkg::*;

  logic [W-1:0] raw_c;
  logic         carry_c;
  logic [W-1:0] mag_c;
  sign_e        sign_c;

  usm_cpl_adder #(.W(W)) u_add (
    .a     (op_m),
    .b     (op_n),
    .raw   (raw_c),
    .carry (carry_c)
  );

  usm_magfix #(.W(W)) u_fix (
    .raw   (raw_c),
    .carry (carry_c),
    .mag   (mag_c)
  );

  assign sign_c = carry_c ? SGN_POS : SGN_NEG;

  if (OUT_REG) begin : g_reg
    logic         rst_q_n;
    logic         vld_q, vld_d;
    logic [W-1:0] mag_q, mag_d;
    logic         neg_q, neg_d;
    logic         cy_q,  cy_d;

    usm_rst_sync #(.STAGES(SYNC_STAGES)) u_rs (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_n_sync (rst_q_n)
    );

    always_comb begin
      vld_d = in_valid;
      mag_d = mag_q;
      neg_d = neg_q;
      cy_d  = cy_q;
      if (in_valid) begin
        mag_d = mag_c;
        neg_d = (sign_c == SGN_NEG);
        cy_d  = carry_c;
      end
    end

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        vld_q <= 1'b0;
        mag_q <= '0;
        neg_q <= 1'b0;
        cy_q  <= 1'b0;
      end else begin
        vld_q <= vld_d;
        mag_q <= mag_d;
        neg_q <= neg_d;
        cy_q  <= cy_d;
      end
    end

    assign out_valid = vld_q;
    assign mag       = mag_q;
    assign neg       = neg_q;
    assign end_carry = cy_q;

    a_r4_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
      out_valid |-> !(neg && mag == '0));
    a_r5_sign_vs_carry: assert property (@(posedge clk) disable iff (!rst_q_n)
      out_valid |-> (neg != end_carry));
    a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_q_n)
      in_valid |=> out_valid);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
      !in_valid |=> ($stable(mag) && $stable(neg) && $stable(end_carry)));
    a_r2_magnitude: assert property (@(posedge clk) disable iff (!rst_q_n)
      (in_valid && op_m >= op_n) |=> (mag == $past(op_m) - $past(op_n)));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign mag       = mag_c;
    assign neg       = (sign_c == SGN_NEG);
    assign end_carry = carry_c;
  end
endmodule

// File: tb/sim_usub_signmag.sv
module sim_usub_signmag;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        v;
  logic [3:0]  m4, n4, mag4;
  logic [7:0]  m8, n8, mag8;
  logic [15:0] m16, n16, mag16;
  logic ov4, ov8, ov16, ng4, ng8, ng16, cy4, cy8, cy16;

  int checks = 0;
  int errors = 0;

  usub_signmag #(.W(4), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .op_m(m4), .op_n(n4),
    .out_valid(ov4), .mag(mag4), .neg(ng4), .end_carry(cy4));
  usub_signmag #(.W(8), .OUT_REG(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .op_m(m8), .op_n(n8),
    .out_valid(ov8), .mag(mag8), .neg(ng8), .end_carry(cy8));
  usub_signmag #(.W(16), .OUT_REG(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .op_m(m16), .op_n(n16),
    .out_valid(ov16), .mag(mag16), .neg(ng16), .end_carry(cy16));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compares one result against integer reference; tag names R1..R5
  task automatic chk_res(input longint m, input longint n, input longint mag,
                         input logic ng, input logic cy);
    longint em;
    logic   en;
    em = (m >= n) ? m - n : n - m;
    en = (m < n);
    chk(m == n ? "R4 mag" : (en ? "R3 mag" : "R2 mag"), mag, em);
    chk(en ? "R3 neg" : "R2 neg", ng, en);
    chk("R1 carry", cy, m >= n);
    chk("R5 neg vs carry", ng, !cy);
  endtask

  task automatic step(input logic [3:0] a4, input logic [3:0] b4,
                      input logic [7:0] a8, input logic [7:0] b8,
                      input logic [15:0] a16, input logic [15:0] b16);
    @(negedge clk);
    v = 1'b1; m4 = a4; n4 = b4; m8 = a8; n8 = b8; m16 = a16; n16 = b16;
    #1;
    chk_res(a16, b16, mag16, ng16, cy16);   // R6 combinational variant
    chk("R6 comb valid", ov16, 1);
    @(negedge clk);
    chk("R6 reg valid", ov4, 1);
    chk_res(a4, b4, mag4, ng4, cy4);
    chk_res(a8, b8, mag8, ng8, cy8);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] h4; logic ht; logic hc; logic [7:0] h8;
    v = 0; m4 = 0; n4 = 0; m8 = 0; n8 = 0; m16 = 0; n16 = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", ov4, 0);
    chk("R8 reset mag", mag8, 0);
    chk("R8 reset neg", ng8, 0);
    chk("R8 reset carry", cy8, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 sync release mag", mag4, 0);
    repeat (3) @(negedge clk);

    // R2 R3 stated examples
    step(4'd4, 4'd7, 8'h54, 8'h43, 16'd35, 16'd17);
    chk("R3 4-7 mag", mag4, 3);
    chk("R2 0x54-0x43", mag8, 8'h11);
    step(4'd7, 4'd7, 8'h43, 8'h54, 16'd0, 16'hFFFF);
    chk("R3 0x43-0x54", {ng8, mag8}, 9'h111);
    chk("R4 equal neg", ng4, 0);

    // R6 latency: registered valid must not rise before the edge
    @(negedge clk);
    v = 1'b0;
    @(negedge clk);
    chk("R6 valid drop", ov4, 0);
    v = 1'b1; m4 = 4'd1; n4 = 4'd2;
    #1;
    chk("R6 not early", ov4, 0);
    @(negedge clk);
    chk("R6 one edge", ov4, 1);
    chk("R6 result", mag4, 1);

    // R7 hold with in_valid low
    h4 = mag4; ht = ng4; hc = cy4; h8 = mag8;
    v = 1'b0; m4 = 4'd15; n4 = 4'd0; m8 = 8'h00; n8 = 8'hFF;
    @(negedge clk);
    chk("R7 hold mag", mag4, h4);
    chk("R7 hold neg", ng4, ht);
    chk("R7 hold carry", cy4, hc);
    chk("R7 hold mag8", mag8, h8);

    // exhaustive 4-bit with random 8/16-bit pairs
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        step(4'(i), 4'(j), 8'($urandom), 8'($urandom),
             16'($urandom), 16'($urandom));
      end
    end
    // boundaries
    step(4'd0, 4'd15, 8'h00, 8'hFF, 16'h0000, 16'hFFFF);
    step(4'd15, 4'd0, 8'hFF, 8'h00, 16'hFFFF, 16'h0000);
    step(4'd8, 4'd8, 8'h80, 8'h80, 16'h8000, 16'h8000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule